// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of a burst access to one bank of a synchronous DRAM. The bank's rows have 256 columns, so the address is 8 bits wide. A mode word, loaded while no burst runs, sets two things: how many beats a burst has (1, 2, 4, 8, or an endless full-page burst) and whether the beats are visited in linear or interleaved order. A read or write command strobe loads a start column. From the next clock on, the block presents one column address per cycle, flags the final beat of a finite burst, and then goes idle.

A command that arrives while a burst is running restarts the sequence at once from the new start column. A stop request cuts the running burst short. A full-page burst walks the whole row in ascending order. After column 255 it wraps to column 0 and keeps going until a stop or a new command ends it. The block is meant to sit between the command decoder and the column decoder of a bank. Row activation, refresh, bank timing and the data path are handled elsewhere.

Mode word layout: bits [2:0] hold the length code and bit 3 holds the ordering (0 = linear, 1 = interleaved).

Top module: `burst_col_gen`

## Requirements
- R1: After reset `beat_valid` and `beat_last` are 0 and `col_addr` is 0. The mode word is 4'b0000, which means length 1 and linear order. Whenever `beat_valid` is 0, both `col_addr` and `beat_last` are 0.
- R2: When `cmd_valid` is 1 at a clock edge, `beat_valid` is 1 in the following cycle and `col_addr` equals the sampled `cmd_col`. Beat k (k = 0, 1, ...) appears k cycles after that.
- R3: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 beats. `beat_valid` falls in the cycle after the last beat.
- R4: Length codes 3'b100, 3'b101 and 3'b110 are reserved. Each of them gives a burst of one beat.
- R5: In linear order (bit 3 = 0), a finite burst of length L keeps the upper address bits of the start column. The low log2(L) bits of beat k are (start + k) mod L, so the burst wraps inside its aligned block.
- R6: In interleaved order (bit 3 = 1), beat k of a finite burst of length L has address start XOR k, with k confined to the low log2(L) bits.
- R7: Length code 3'b111 gives a full-page burst. Beat k has address (start + k) mod 256, and the burst never ends by itself. `beat_last` is never 1 in this mode. Bit 3 has no effect here: the order is always ascending.
- R8: `beat_last` is 1 only on the final beat of a finite burst.
- R9: A command that arrives during a burst replaces the burst. The next cycle shows beat 0 at the new start column, and a full new burst follows.
- R10: When `stop` is 1 at a clock edge with no command, `beat_valid` is 0 from the next cycle on. If `cmd_valid` is also 1 at that edge, the command wins.
- R11: `mode_load` takes effect at a clock edge only if `beat_valid` is 0 in that cycle. A load during a burst is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Write `mode_word` into the mode register (only accepted when idle) |
| mode_word | input | 4 | [2:0] length code, [3] 1 = interleaved order |
| cmd_valid | input | 1 | Read or write command strobe; starts or restarts a burst |
| cmd_col | input | 8 | Start column of the command |
| stop | input | 1 | Stop request; ends the running burst |
| col_addr | output | 8 | Column address of the current beat (0 when idle) |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_last | output | 1 | The current beat is the last of a finite burst |

## Verification
Start column 0x35 is run through every finite length in both orders. Its low bits are neither zero nor all ones, so linear wrap inside the aligned block (0x37 then 0x30) can be told apart from interleaved XOR order and from a plain increment. Start columns 0x6E, 0xFF and 0xF8 repeat the check where the block is at the top of the page. A reserved code tells "treated as length 1" apart from any longer length. A full-page burst started at 0xFD runs past 255 and more than a whole page, which separates wrapping to 0 from ending or from staying in one block. Restart in mid-burst, stop, stop together with a command, and a mode load during a burst each show a different priority outcome at the ports.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  // Burst length codes held in mode bits [2:0]
  typedef enum logic [2:0] {
    BLEN_1    = 3'b000,
    BLEN_2    = 3'b001,
    BLEN_4    = 3'b010,
    BLEN_8    = 3'b011,
    BLEN_PAGE = 3'b111
  } blen_e;

  localparam int MODE_W = 4;

  typedef struct packed {
    logic       ileave;  // 1: interleaved ordering
    logic [2:0] blen;    // burst length code
  } mode_t;

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en,
  input  logic [MODE_W-1:0]   mode_in,
  output logic [MODE_W-1:0]   mode_q,
  output logic [COL_W-1:0]    len_mask,
  output logic                fpage,
  output logic                ileave
);

  mode_t mode_r;

  // Burst length minus one, as a mask over the low address bits.
  function automatic logic [COL_W-1:0] code_to_mask(input logic [2:0] code);
    logic [COL_W-1:0] m;
    case (code)
      BLEN_2:    m = COL_W'(1);
      BLEN_4:    m = COL_W'(3);
      BLEN_8:    m = COL_W'(7);
      BLEN_PAGE: m = '1;
      default:   m = '0;   // length 1 and reserved codes
    endcase
    return m;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_r <= '0;
    else if (load_en) mode_r <= mode_t'(mode_in);
  end

  assign mode_q   = mode_r;
  assign len_mask = code_to_mask(mode_r.blen);
  assign fpage    = (mode_r.blen == BLEN_PAGE);
  assign ileave   = mode_r.ileave;

endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             stop,
  input  logic [COL_W-1:0] len_mask,
  input  logic             fpage,
  output logic             active,
  output logic [COL_W-1:0] start_col,
  output logic [COL_W-1:0] beat_cnt,
  output logic             last,
  output logic             ev_restart,
  output logic             ev_stop_cut,
  output logic             ev_natural_end
);

  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic             active_r;
  logic [COL_W-1:0] start_r;
  logic [COL_W-1:0] cnt_r;

  assign last = active_r && !fpage && (cnt_r == len_mask);

  assign ev_restart     = cmd_valid && active_r;
  assign ev_stop_cut    = stop && active_r && !cmd_valid;
  assign ev_natural_end = last && !cmd_valid && !stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_r <= 1'b0;
      start_r  <= '0;
      cnt_r    <= '0;
    end else if (cmd_valid) begin
      active_r <= 1'b1;
      start_r  <= cmd_col;
      cnt_r    <= '0;
    end else if (active_r) begin
      if (stop || last) active_r <= 1'b0;
      else              cnt_r    <= cnt_r + ONE;   // full page wraps naturally
    end
  end

  assign active    = active_r;
  assign start_col = start_r;
  assign beat_cnt  = cnt_r;

endmodule

// File: rtl/col_addr_calc.sv
module col_addr_calc #(
  parameter int COL_W = 8
) (
  input  logic             active,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] beat_cnt,
  input  logic [COL_W-1:0] len_mask,
  input  logic             ileave,
  input  logic             fpage,
  output logic [COL_W-1:0] col_addr
);

  // Ascending order wrapping inside the aligned block selected by mask.
  function automatic logic [COL_W-1:0] seq_addr(input logic [COL_W-1:0] s,
                                                input logic [COL_W-1:0] k,
                                                input logic [COL_W-1:0] m);
    logic [COL_W-1:0] sum;
    sum = s + k;
    return (s & ~m) | (sum & m);
  endfunction

  // Start column with the beat index folded into the low bits.
  function automatic logic [COL_W-1:0] xor_addr(input logic [COL_W-1:0] s,
                                                input logic [COL_W-1:0] k,
                                                input logic [COL_W-1:0] m);
    return s ^ (k & m);
  endfunction

  always_comb begin
    if (!active)                col_addr = '0;
    else if (ileave && !fpage)  col_addr = xor_addr(start_col, beat_cnt, len_mask);
    else                        col_addr = seq_addr(start_col, beat_cnt, len_mask);
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              cmd_valid,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              stop,
  output logic [COL_W-1:0]  col_addr,
  output logic              beat_valid,
  output logic              beat_last
);

  logic [MODE_W-1:0] mode_q;
  logic [COL_W-1:0]  len_mask;
  logic              fpage;
  logic              ileave;
  logic              active;
  logic [COL_W-1:0]  start_col;
  logic [COL_W-1:0]  beat_cnt;
  logic              last;
  logic              ev_restart;
  logic              ev_stop_cut;
  logic              ev_natural_end;
  logic              mode_accept;

  assign mode_accept = mode_load && !active;

  burst_mode_reg #(.COL_W(COL_W)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (mode_accept),
    .mode_in  (mode_word),
    .mode_q   (mode_q),
    .len_mask (len_mask),
    .fpage    (fpage),
    .ileave   (ileave)
  );

  burst_seq #(.COL_W(COL_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_col        (cmd_col),
    .stop           (stop),
    .len_mask       (len_mask),
    .fpage          (fpage),
    .active         (active),
    .start_col      (start_col),
    .beat_cnt       (beat_cnt),
    .last           (last),
    .ev_restart     (ev_restart),
    .ev_stop_cut    (ev_stop_cut),
    .ev_natural_end (ev_natural_end)
  );

  col_addr_calc #(.COL_W(COL_W)) u_addr (
    .active    (active),
    .start_col (start_col),
    .beat_cnt  (beat_cnt),
    .len_mask  (len_mask),
    .ileave    (ileave),
    .fpage     (fpage),
    .col_addr  (col_addr)
  );

  assign beat_valid = active;
  assign beat_last  = last;

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_load,
  input logic              cmd_valid,
  input logic [COL_W-1:0]  cmd_col,
  input logic              stop,
  input logic [COL_W-1:0]  col_addr,
  input logic              beat_valid,
  input logic              beat_last,
  input logic [MODE_W-1:0] mode_q,
  input logic              fpage,
  input logic              ev_restart,
  input logic              ev_stop_cut,
  input logic              ev_natural_end
);

  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |-> (col_addr == '0) && !beat_last);  // R1

  AST_CMD_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> beat_valid && (col_addr == $past(cmd_col)));  // R2

  AST_RESTART_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_restart |=> beat_valid && (col_addr == $past(cmd_col)));  // R9

  AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> !fpage);  // R7

  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && fpage && !stop && !cmd_valid
      |=> beat_valid && (col_addr == $past(col_addr) + ONE));  // R7

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_natural_end |=> !beat_valid);  // R8

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop_cut |=> !beat_valid);  // R10

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && mode_load |=> $stable(mode_q));  // R11

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mode_load      (mode_load),
  .cmd_valid      (cmd_valid),
  .cmd_col        (cmd_col),
  .stop           (stop),
  .col_addr       (col_addr),
  .beat_valid     (beat_valid),
  .beat_last      (beat_last),
  .mode_q         (mode_q),
  .fpage          (fpage),
  .ev_restart     (ev_restart),
  .ev_stop_cut    (ev_stop_cut),
  .ev_natural_end (ev_natural_end)
);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_load = 1'b0;
  logic [3:0] mode_word = '0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_col = '0;
  logic       stop = 1'b0;
  logic [7:0] col_addr;
  logic       beat_valid;
  logic       beat_last;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  burst_col_gen uut (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
    .cmd_valid(cmd_valid), .cmd_col(cmd_col), .stop(stop),
    .col_addr(col_addr), .beat_valid(beat_valid), .beat_last(beat_last)
  );

  // mode, start column, beats, expected addresses (beat 0 in low byte)
  typedef struct packed {
    logic [3:0]  mode;
    logic [7:0]  start;
    logic [3:0]  nbeats;
    logic [63:0] addrs;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{4'h0, 8'h35, 4'd1, 64'h35},                 // len 1
    '{4'h1, 8'h35, 4'd2, 64'h3435},               // len 2 linear
    '{4'h2, 8'h35, 4'd4, 64'h34373635},           // len 4 linear
    '{4'h3, 8'h35, 4'd8, 64'h3433323130373635},   // len 8 linear
    '{4'hB, 8'h35, 4'd8, 64'h3233303136373435},   // len 8 interleaved
    '{4'hA, 8'h6E, 4'd4, 64'h6D6C6F6E},           // len 4 interleaved
    '{4'h9, 8'hFF, 4'd2, 64'hFEFF},               // len 2 interleaved
    '{4'h5, 8'h12, 4'd1, 64'h12},                 // reserved code
    '{4'h3, 8'hF8, 4'd8, 64'hFFFEFDFCFBFAF9F8}    // len 8 top of page
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_mode(input logic [3:0] m);
    mode_word = m; mode_load = 1'b1;
    step();
    mode_load = 1'b0;
  endtask

  task automatic issue(input logic [7:0] c);
    cmd_col = c; cmd_valid = 1'b1;
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic expect_beat(input logic [7:0] a, input bit lst, input string tag);
    check(beat_valid === 1'b1, {tag, " valid"}, beat_valid, 1);
    check(col_addr === a, {tag, " addr"}, col_addr, a);
    check(beat_last === lst, {"R8 last ", tag}, beat_last, lst);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(); step();
    rst_n = 1'b1;
    step();
    // R1: reset state at the ports
    check(beat_valid === 1'b0, "R1 valid", beat_valid, 0);
    check(beat_last === 1'b0, "R1 last", beat_last, 0);
    check(col_addr === 8'h00, "R1 addr", col_addr, 0);
    // R1: reset mode is length 1, linear
    issue(8'h5A);
    expect_beat(8'h5A, 1'b1, "R1 R2 reset mode");
    step();
    check(beat_valid === 1'b0, "R1 single beat", beat_valid, 0);

    // Vector table: R2 R3 R4 R5 R6 R8
    for (int v = 0; v < NVEC; v++) begin
      load_mode(VECS[v].mode);
      issue(VECS[v].start);
      for (int k = 0; k < int'(VECS[v].nbeats); k++) begin
        expect_beat(VECS[v].addrs[8*k +: 8], (k == int'(VECS[v].nbeats) - 1),
                    $sformatf("R3 R4 R5 R6 vec%0d beat%0d", v, k));
        step();
      end
      check(beat_valid === 1'b0, $sformatf("R3 R4 end vec%0d", v), beat_valid, 0);
    end

    // R7: full page from 0xFD runs past 255 and over a whole page
    load_mode(4'h7);
    issue(8'hFD);
    for (int k = 0; k < 260; k++) begin
      expect_beat(8'((8'hFD + k) & 8'hFF), 1'b0, $sformatf("R7 page beat%0d", k));
      step();
    end
    // R10: stop ends the burst
    stop = 1'b1;
    step();
    stop = 1'b0;
    check(beat_valid === 1'b0, "R10 stop page", beat_valid, 0);
    check(col_addr === 8'h00, "R1 idle addr", col_addr, 0);

    // R7: ordering bit ignored in full page
    load_mode(4'hF);
    issue(8'h10);
    for (int k = 0; k < 5; k++) begin
      expect_beat(8'(8'h10 + k), 1'b0, "R7 page ileave");
      step();
    end
    stop = 1'b1; step(); stop = 1'b0;

    // R9: restart mid-burst
    load_mode(4'h3);
    issue(8'h35);
    step(); step();          // beat 2 now shown
    expect_beat(8'h37, 1'b0, "R5 pre-restart");
    issue(8'h80);
    for (int k = 0; k < 8; k++) begin
      expect_beat(8'(8'h80 + k), (k == 7), "R9 restart");
      step();
    end
    check(beat_valid === 1'b0, "R9 restart end", beat_valid, 0);

    // R10: stop with a command at the same edge, command wins
    issue(8'h40);
    stop = 1'b1; cmd_col = 8'hC3; cmd_valid = 1'b1;
    step();
    stop = 1'b0; cmd_valid = 1'b0;
    expect_beat(8'hC3, 1'b0, "R10 cmd beats stop");
    step();
    expect_beat(8'hC4, 1'b0, "R10 cmd beats stop b1");

    // R11: mode load during burst ignored (try length 1)
    mode_word = 4'h0; mode_load = 1'b1;
    step();
    mode_load = 1'b0;
    stop = 1'b1; step(); stop = 1'b0;
    issue(8'h20);
    for (int k = 0; k < 8; k++) begin
      expect_beat(8'(8'h20 + k), (k == 7), "R11 mode kept");
      step();
    end
    check(beat_valid === 1'b0, "R11 end", beat_valid, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule